// File: doc/BRIEF.md
# Aligned Transfer Segmentation Engine

This block takes one memory-access request and turns it into an ordered list of bus transactions. A request carries a start address, a byte count and a direction flag (read or write). Each transaction the block emits is a 2-byte access, a 4-byte access, or a burst whose length is a multiple of 8 bytes. Every transaction address is naturally aligned to its access size, and the block keeps the number of transactions small.

The request side uses a valid/ready handshake and accepts a new request only while the block is idle. Each segment is offered on a second valid/ready handshake as a command code, a segment address and a segment byte count. As soon as a segment is taken, the next one is offered in the following cycle. When the last segment has been taken, the block raises a one-cycle completion pulse. A request that breaks the alignment rules raises a one-cycle error pulse and produces no segment. The block does not move data and does not serialize anything onto a wire. It only plans the segments.

Top module: `xfer_segmenter`

## Requirements
- R1: After reset, `req_ready` is 1, and `seg_valid`, `done` and `err` are 0.
- R2: The command code is the access class in bits [2:1] (0 = 2-byte, 1 = 4-byte, 2 = burst) and the direction in bit 0 (0 = read, 1 = write). The six codes are therefore: 2-byte read 0, 2-byte write 1, 4-byte read 2, 4-byte write 3, burst read 4, burst write 5.
- R3: A 2-byte segment is issued when the current address modulo 8 is 2 or 6, or when exactly 2 bytes remain.
- R4: When R3 does not apply, a 4-byte segment is issued if the address modulo 8 is 4 or if 6 or fewer bytes remain.
- R5: In every other case a burst is issued. Its length is the remaining count rounded down to a multiple of 8, limited to `BURST_MAX` (240 bytes by default).
- R6: The first segment starts at the request address. Each later segment starts where the previous one ended. The segment lengths add up to the (padded) request length.
- R7: A request with an odd address, or a read with an odd length, is accepted and rejected. `err` is 1 in the cycle after acceptance, no segment is produced, and the block stays idle.
- R8: A write with an odd length is treated as one byte longer, so the extra zero byte is part of the last segment.
- R9: `req_ready` is 1 only while no segment is pending. A request presented while segments are pending is ignored. The first segment is valid in the cycle after acceptance.
- R10: While `seg_valid` is 1 and `seg_ready` is 0, the command, address and length hold their values.
- R11: `done` is a one-cycle pulse in the cycle after the last segment is taken. The next segment follows a taken segment with no idle cycle in between. A valid request of length 0 produces no segment and gives `done` in the cycle after acceptance.
- R12: A 260-byte read starting at an address with low byte 0x02 yields segments of 2, 4, 240, 8, 4 and 2 bytes, at offsets 0, 2, 6, 246, 254 and 258.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Request start address |
| req_len | input | LEN_W | Request byte count |
| req_write | input | 1 | 1 = write, 0 = read |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Downstream takes the segment |
| seg_cmd | output | 3 | Command code (R2) |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment byte count |
| done | output | 1 | One-cycle pulse after the last segment is taken |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The end of one request and the start of the next can fall in the same cycle. The completion pulse of one request (or the error pulse of a rejected one) is visible in the very cycle in which the next request can be taken. The bench provokes this overlap for every request in its sweep: it presents the next request in the same cycle in which it sees `done` or `err`. It then judges the overlap by three things. `req_ready` must be high in that cycle. The pulse must have dropped one cycle later. The first segment of the new request must appear at that point with its own address and command.

// File: rtl/xseg_pkg.sv
package xseg_pkg;

  // access class, placed in bits [2:1] of the command code
  typedef enum logic [1:0] {
    SZ_HALF  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_BURST = 2'd2
  } seg_size_e;

  // the direction sits in the low bit, so a write code is the read code plus one
  function automatic logic [2:0] seg_code(seg_size_e sz, logic wr);
    return {sz, wr};
  endfunction

endpackage

// File: rtl/xseg_req_check.sv
module xseg_req_check #(
  parameter int LEN_W = 16
) (
  input  logic             addr_lsb,
  input  logic [LEN_W-1:0] len,
  input  logic             wr,
  output logic             bad,
  output logic [LEN_W:0]   pad_len
);

  logic odd_len;

  always_comb begin
    odd_len = len[0];
    // start address must be even; a read must also have an even length
    bad     = addr_lsb | (odd_len & ~wr);
    // an odd write gains one zero byte at its end
    pad_len = {1'b0, len} + {{LEN_W{1'b0}}, odd_len & wr};
  end

endmodule

// File: rtl/xseg_size_pick.sv
module xseg_size_pick
  import xseg_pkg::*;
#(
  parameter int REM_W     = 17,
  parameter int BURST_MAX = 240
) (
  input  logic [2:0]       align,
  input  logic [REM_W-1:0] rem,
  output seg_size_e        size,
  output logic [REM_W-1:0] nbytes
);

  localparam logic [REM_W-1:0] CAP = REM_W'(BURST_MAX);

  logic [REM_W-1:0] floor8;

  always_comb begin
    floor8 = rem & ~REM_W'(7);
    if (align == 3'd2 || align == 3'd6 || rem == REM_W'(2)) begin
      size   = SZ_HALF;
      nbytes = REM_W'(2);
    end else if (align == 3'd4 || rem <= REM_W'(6)) begin
      size   = SZ_WORD;
      nbytes = REM_W'(4);
    end else begin
      size   = SZ_BURST;
      nbytes = (floor8 > CAP) ? CAP : floor8;
    end
  end

endmodule

// File: rtl/xseg_seg_reg.sv
module xseg_seg_reg #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              take,
  input  logic [2:0]        cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LEN_W-1:0]  len_in,
  output logic              valid,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cmd   <= '0;
      addr  <= '0;
      len   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      cmd   <= cmd_in;
      addr  <= addr_in;
      len   <= len_in;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/xfer_segmenter.sv
module xfer_segmenter
  import xseg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BURST_MAX = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [2:0]        seg_cmd,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              done,
  output logic              err
);

  localparam int REM_W = LEN_W + 1;

  logic             wr_q;
  logic [REM_W-1:0] rem_q;
  logic             done_q;
  logic             err_q;

  logic             bad;
  logic [REM_W-1:0] pad_len;
  logic             take_req;
  logic             start_ok;
  logic             fire;
  logic             last;
  logic             load;
  logic [ADDR_W-1:0] next_addr;
  logic [REM_W-1:0]  next_rem;
  logic [ADDR_W-1:0] pick_addr;
  logic [REM_W-1:0]  pick_rem;
  logic              pick_wr;
  seg_size_e         pick_size;
  logic [REM_W-1:0]  pick_bytes;

  xseg_req_check #(.LEN_W(LEN_W)) u_check (
    .addr_lsb (req_addr[0]),
    .len      (req_len),
    .wr       (req_write),
    .bad      (bad),
    .pad_len  (pad_len)
  );

  // a pending segment means the block is busy
  assign req_ready = ~seg_valid;
  assign take_req  = req_valid & ~seg_valid;
  assign start_ok  = take_req & ~bad;
  assign fire      = seg_valid & seg_ready;

  // where the request stands once the current segment is taken
  assign next_addr = seg_addr + ADDR_W'(seg_len);
  assign next_rem  = rem_q - REM_W'(seg_len);
  assign last      = (next_rem == '0);

  // one selector serves both the first segment and every later one
  assign pick_addr = seg_valid ? next_addr : req_addr;
  assign pick_rem  = seg_valid ? next_rem  : pad_len;
  assign pick_wr   = seg_valid ? wr_q      : req_write;

  xseg_size_pick #(.REM_W(REM_W), .BURST_MAX(BURST_MAX)) u_pick (
    .align  (pick_addr[2:0]),
    .rem    (pick_rem),
    .size   (pick_size),
    .nbytes (pick_bytes)
  );

  assign load = (start_ok & (pad_len != '0)) | (fire & ~last);

  xseg_seg_reg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .take    (fire),
    .cmd_in  (seg_code(pick_size, pick_wr)),
    .addr_in (pick_addr),
    .len_in  (LEN_W'(pick_bytes)),
    .valid   (seg_valid),
    .cmd     (seg_cmd),
    .addr    (seg_addr),
    .len     (seg_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      rem_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (take_req) wr_q <= req_write;
      if (start_ok)  rem_q <= pad_len;
      else if (fire) rem_q <= next_rem;
      done_q <= (start_ok & (pad_len == '0)) | (fire & last);
      err_q  <= take_req & bad;
    end
  end

  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/xseg_checker.sv
module xseg_checker #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BURST_MAX = 240
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [2:0]        seg_cmd,
  input logic [ADDR_W-1:0] seg_addr,
  input logic [LEN_W-1:0]  seg_len,
  input logic              done,
  input logic              err
);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_cmd) &&
                                   $stable(seg_addr) && $stable(seg_len)));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> !req_ready);

  a_r9_take_answers: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (seg_valid || done || err));

  a_r11_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!seg_valid && !err));

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> !seg_valid);

  a_r5_len_legal: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_len == LEN_W'(2) || seg_len == LEN_W'(4) ||
                   (seg_len[2:0] == 3'd0 && seg_len >= LEN_W'(8) &&
                    seg_len <= LEN_W'(BURST_MAX))));

  a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> ((seg_len == LEN_W'(2)) ? (seg_addr[0] == 1'b0) :
                   (seg_len == LEN_W'(4)) ? (seg_addr[1:0] == 2'd0) :
                                            (seg_addr[2:0] == 3'd0)));

  a_r2_code_class: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_cmd[2:1] == ((seg_len == LEN_W'(2)) ? 2'd0 :
                                    (seg_len == LEN_W'(4)) ? 2'd1 : 2'd2)));

endmodule

bind xfer_segmenter xseg_checker #(
  .ADDR_W    (ADDR_W),
  .LEN_W     (LEN_W),
  .BURST_MAX (BURST_MAX)
) u_xseg_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .seg_valid (seg_valid),
  .seg_ready (seg_ready),
  .seg_cmd   (seg_cmd),
  .seg_addr  (seg_addr),
  .seg_len   (seg_len),
  .done      (done),
  .err       (err)
);

// File: tb/test_xfer_segmenter.sv
module test_xfer_segmenter;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        req_write;
  logic        seg_valid;
  logic        seg_ready;
  logic [2:0]  seg_cmd;
  logic [31:0] seg_addr;
  logic [15:0] seg_len;
  logic        done;
  logic        err;

  int checks = 0;
  int errors = 0;
  int stall_ctr = 0;
  int nlog = 0;
  int log_len [16];
  int log_off [16];

  always #10 clk = ~clk;

  xfer_segmenter i_xfer_segmenter (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_write (req_write),
    .seg_valid (seg_valid),
    .seg_ready (seg_ready),
    .seg_cmd   (seg_cmd),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .done      (done),
    .err       (err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // segment size from the selection rules R3, R4 and R5
  function automatic int exp_pick(input int al, input int rem);
    int f;
    if (al == 2 || al == 6 || rem == 2) return 2;
    if (al == 4 || rem <= 6) return 4;
    f = rem - (rem % 8);
    return (f > 240) ? 240 : f;
  endfunction

  // starts and ends at a falling edge; on return, done or err is visible
  task automatic run_req(input logic [31:0] a, input int l, input bit w);
    bit          bad;
    int          rem;
    int          total;
    int          n;
    int          st;
    logic [2:0]  code;
    logic [31:0] cur;
    string       t;
    bad = a[0] || (!w && (l % 2 == 1));
    rem = l + ((w && (l % 2 == 1)) ? 1 : 0);
    chk("R9 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a; req_len = l[15:0]; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    nlog = 0;
    total = 0;
    if (bad) begin
      chk("R7 err pulse", {31'd0, err}, 32'd1);
      chk("R7 no segment", {31'd0, seg_valid}, 32'd0);
      chk("R7 no done", {31'd0, done}, 32'd0);
      return;
    end
    if (rem == 0) begin
      chk("R11 zero length done", {31'd0, done}, 32'd1);
      chk("R11 zero length no segment", {31'd0, seg_valid}, 32'd0);
      return;
    end
    chk("R7 legal request not flagged", {31'd0, err}, 32'd0);
    chk("R11 previous done dropped", {31'd0, done}, 32'd0);
    cur = a;
    while (rem > 0) begin
      n = exp_pick(int'(cur[2:0]), rem);
      code = 3'((n == 2) ? 0 : (n == 4) ? 2 : 4) + {2'b00, w};
      t = (n == 2) ? "R3 2-byte length" : (n == 4) ? "R4 4-byte length" : "R5 burst length";
      chk("R11 segment valid without bubble", {31'd0, seg_valid}, 32'd1);
      chk("R9 busy not ready", {31'd0, req_ready}, 32'd0);
      chk("R2 command code", {29'd0, seg_cmd}, {29'd0, code});
      chk("R6 segment address", seg_addr, cur);
      chk(t, {16'd0, seg_len}, n);
      if (nlog < 16) begin
        log_len[nlog] = int'(seg_len);
        log_off[nlog] = int'(seg_addr - a);
        nlog++;
      end
      total += int'(seg_len);
      st = stall_ctr % 3;
      stall_ctr++;
      for (int s = 0; s < st; s++) begin
        seg_ready = 1'b0;
        req_valid = 1'b1; req_addr = 32'hDEAD_BEE0; req_len = 16'd8; req_write = ~w;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 held valid", {31'd0, seg_valid}, 32'd1);
        chk("R10 held address / R9 busy request ignored", seg_addr, cur);
        chk("R10 held length", {16'd0, seg_len}, n);
        chk("R10 held command", {29'd0, seg_cmd}, {29'd0, code});
      end
      seg_ready = 1'b1;
      @(negedge clk);
      seg_ready = 1'b0;
      cur = cur + 32'(n);
      rem = rem - n;
    end
    chk("R11 done after last", {31'd0, done}, 32'd1);
    chk("R11 no segment with done", {31'd0, seg_valid}, 32'd0);
    chk("R9 ready after last", {31'd0, req_ready}, 32'd1);
    if (w && (l % 2 == 1)) chk("R8 padded total", total, l + 1);
    else                   chk("R6 total bytes", total, l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_len = '0; req_write = 1'b0;
    seg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset seg_valid", {31'd0, seg_valid}, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset err", {31'd0, err}, 32'd0);

    // R12 worked example: fixed list, independent of the selection model
    run_req(32'h6003_0002, 260, 1'b0);
    chk("R12 segment count", nlog, 6);
    chk("R12 len0", log_len[0], 2);   chk("R12 off0", log_off[0], 0);
    chk("R12 len1", log_len[1], 4);   chk("R12 off1", log_off[1], 2);
    chk("R12 len2", log_len[2], 240); chk("R12 off2", log_off[2], 6);
    chk("R12 len3", log_len[3], 8);   chk("R12 off3", log_off[3], 246);
    chk("R12 len4", log_len[4], 4);   chk("R12 off4", log_off[4], 254);
    chk("R12 len5", log_len[5], 2);   chk("R12 off5", log_off[5], 258);

    // sweep of every even alignment, length and direction
    for (int a = 0; a < 8; a += 2) begin
      for (int l = 0; l <= 300; l++) begin
        run_req(32'h6003_0000 + 32'(a), l, 1'b0);
        run_req(32'h6003_0000 + 32'(a), l, 1'b1);
      end
    end

    // R7: odd start addresses are rejected in both directions
    for (int a = 1; a < 8; a += 2) begin
      run_req(32'h0000_1000 + 32'(a), 8, 1'b0);
      run_req(32'h0000_1000 + 32'(a), 9, 1'b1);
    end

    // longest requests: R8 padding past the 16-bit count, R5 repeated cap
    run_req(32'h0000_0002, 65535, 1'b1);
    run_req(32'h1000_0004, 65534, 1'b0);

    @(negedge clk);
    chk("R11 done is one cycle", {31'd0, done}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule